// File: doc/BRIEF.md
# Interleaved Single-Symbol-Correcting Block Codec

This block protects a 64-bit frame word on a serial link with a shortened Reed-Solomon code over 4-bit symbols. On the transmit side the word is cut into two 32-bit halves. Each half becomes eight data symbols, and two parity symbols are appended to form a ten-symbol codeword. The symbols of the two codewords are then interleaved into one 80-bit coded block. The block applies the code only; scrambling and framing happen outside it.

On the receive side the 80-bit block is split back into its two codewords. Two syndromes are formed for each codeword. The codec repairs any single bad symbol in each codeword and returns the 64 data bits. Each codeword has its own flag, which marks an error pattern the code cannot repair. Because symbols alternate between the codewords, a short burst of line errors lands as at most one bad symbol per codeword. Such a burst is therefore always repaired.

The encoder and decoder paths are independent. Each takes a valid strobe with its data and returns a valid strobe with its result.

Top module: `rs_ilv_codec`

## Requirements
- R1: The encoder result appears on `enc_out_valid`/`enc_out_data` exactly one clock after `enc_in_valid` is high. `enc_out_valid` is low in every cycle after a cycle without `enc_in_valid`.
- R2: The encoder output is systematic and interleaved. Codeword A takes `enc_in_data[63:32]` and codeword B takes `enc_in_data[31:0]`. Codeword symbol k (k = 0..9) of A sits at output bits [8k+7:8k+4], and the same symbol of B sits at [8k+3:8k]. Data nibble j (bits [4j+3:4j] of the half) is symbol j+2. Symbols 1 and 0 are parity.
- R3: Each codeword c(x) = sum c_k x^k is divisible by g(x) = x^2 + 6x + 8 over GF(16) with x^4+x+1 and alpha = 2. Equivalently, c(2) = c(4) = 0. Example: an A half of 1 gives A symbols 2, 1 and 0 equal to 1, 6 and 8.
- R4: The decoder result appears on `dec_out_valid` exactly two clocks after `dec_in_valid`, and never otherwise.
- R5: An error-free block decodes to its original 64 data bits with both flags low.
- R6: A single nonzero symbol error at any of the ten positions of either codeword is repaired, and the flags stay low.
- R7: One bad symbol in each codeword at the same time is repaired. Any burst confined to 5 consecutive line bits is repaired.
- R8: A codeword whose syndrome pair has exactly one zero member, or whose computed error position is above 9, raises its flag. That codeword's received data nibbles are passed through unchanged. `dec_out_uncorr[1]` belongs to A and `dec_out_uncorr[0]` to B. The flags are low whenever `dec_out_valid` is low.
- R9: A flag on one codeword does not disturb the repair or the output of the other codeword.
- R10: While `rst` is high, `enc_out_valid`, `dec_out_valid` and `dec_out_uncorr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Frame word to encode is present |
| enc_in_data | input | 64 | Frame word to encode |
| enc_out_valid | output | 1 | Coded block is present |
| enc_out_data | output | 80 | Interleaved coded block |
| dec_in_valid | input | 1 | Received coded block is present |
| dec_in_data | input | 80 | Received interleaved coded block |
| dec_out_valid | output | 1 | Decoded word is present |
| dec_out_data | output | 64 | Decoded (repaired) frame word |
| dec_out_uncorr | output | 2 | Per-codeword flag for an error pattern that cannot be repaired (bit 1 = A, bit 0 = B) |

## Verification
Several internal faults show up at the ports within the cycle in which the result is due:

- **Wrong field constant or generator tap:** the encoder output stops having zero syndromes. The block that is still in flight is already wrong.
- **Slip in the interleave map:** a 5-bit burst starts to land two bad symbols in one codeword. The first burst that straddles the slipped pair then either raises a flag or returns wrong data two clocks after entry.
- **Wrong locator or error-value arithmetic:** this shows as a mismatch on a single-symbol repair at a particular position.
- **Stuck stage-one valid register:** this shifts `dec_out_valid` off its fixed two-cycle slot.

// File: rtl/rs_gf_pkg.sv
package rs_gf_pkg;

  localparam int GF_M = 4;
  localparam int GF_ORDER = (1 << GF_M) - 1;

  typedef logic [GF_M-1:0] gf_t;

  // low taps of the primitive polynomial x^4 + x + 1
  localparam gf_t GF_TAPS = 4'b0011;

  function automatic gf_t gf_xtime(gf_t a);
    gf_t r;
    r = {a[GF_M-2:0], 1'b0};
    if (a[GF_M-1]) r = r ^ GF_TAPS;
    return r;
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  function automatic gf_t gf_alpha_pow(int k);
    gf_t r;
    r = gf_t'(1);
    for (int i = 0; i < GF_ORDER; i++) begin
      if (i < k) r = gf_xtime(r);
    end
    return r;
  endfunction

  // a^(order-1) is the inverse for nonzero a
  function automatic gf_t gf_inv(gf_t a);
    gf_t r;
    r = gf_t'(1);
    for (int i = 0; i < GF_ORDER - 1; i++) r = gf_mul(r, a);
    return r;
  endfunction

  // discrete log base alpha; argument must be nonzero
  function automatic gf_t gf_log(gf_t a);
    gf_t p;
    gf_t r;
    logic hit;
    p   = gf_t'(1);
    r   = '0;
    hit = 1'b0;
    for (int i = 0; i < GF_ORDER; i++) begin
      if (!hit && p == a) begin
        r   = gf_t'(i);
        hit = 1'b1;
      end
      p = gf_xtime(p);
    end
    return r;
  endfunction

endpackage

// File: rtl/rs_cw_encoder.sv
module rs_cw_encoder
  import rs_gf_pkg::*;
#(
  parameter int K_SYM = 8
) (
  input  logic [K_SYM*GF_M-1:0] data_i,
  output logic [2*GF_M-1:0]     parity_o
);

  // g(x) = (x + a)(x + a^2) = x^2 + G1 x + G0
  localparam gf_t G1 = gf_alpha_pow(1) ^ gf_alpha_pow(2);
  localparam gf_t G0 = gf_mul(gf_alpha_pow(1), gf_alpha_pow(2));

  gf_t r_hi, r_lo, fb;

  always_comb begin
    r_hi = '0;
    r_lo = '0;
    fb   = '0;
    for (int j = K_SYM - 1; j >= 0; j--) begin
      fb   = data_i[j*GF_M +: GF_M] ^ r_hi;
      r_hi = r_lo ^ gf_mul(fb, G1);
      r_lo = gf_mul(fb, G0);
    end
    parity_o = {r_hi, r_lo};
  end

endmodule

// File: rtl/rs_cw_syndrome.sv
module rs_cw_syndrome
  import rs_gf_pkg::*;
#(
  parameter int N_SYM = 10
) (
  input  logic [N_SYM*GF_M-1:0] cw_i,
  output gf_t                   s1_o,
  output gf_t                   s2_o
);

  localparam gf_t ROOT1 = gf_alpha_pow(1);
  localparam gf_t ROOT2 = gf_alpha_pow(2);

  gf_t acc1, acc2;

  always_comb begin
    acc1 = '0;
    acc2 = '0;
    for (int k = N_SYM - 1; k >= 0; k--) begin
      acc1 = gf_mul(acc1, ROOT1) ^ cw_i[k*GF_M +: GF_M];
      acc2 = gf_mul(acc2, ROOT2) ^ cw_i[k*GF_M +: GF_M];
    end
    s1_o = acc1;
    s2_o = acc2;
  end

endmodule

// File: rtl/rs_cw_corrector.sv
module rs_cw_corrector
  import rs_gf_pkg::*;
#(
  parameter int N_SYM = 10,
  parameter int K_SYM = 8
) (
  input  gf_t                   s1_i,
  input  gf_t                   s2_i,
  input  logic [K_SYM*GF_M-1:0] data_i,
  output logic [K_SYM*GF_M-1:0] data_o,
  output logic                  uncorr_o
);

  localparam int NP = N_SYM - K_SYM;

  gf_t loc, mag;

  always_comb begin
    data_o   = data_i;
    uncorr_o = 1'b0;
    loc      = '0;
    mag      = '0;
    if (s1_i == '0 && s2_i == '0) begin
      uncorr_o = 1'b0;
    end else if (s1_i == '0 || s2_i == '0) begin
      uncorr_o = 1'b1;
    end else begin
      loc = gf_log(gf_mul(s2_i, gf_inv(s1_i)));
      mag = gf_mul(gf_mul(s1_i, s1_i), gf_inv(s2_i));
      if (int'(loc) > N_SYM - 1) begin
        uncorr_o = 1'b1;
      end else begin
        for (int j = 0; j < K_SYM; j++) begin
          if (int'(loc) == j + NP) data_o[j*GF_M +: GF_M] = data_i[j*GF_M +: GF_M] ^ mag;
        end
      end
    end
  end

endmodule

// File: rtl/rs_ilv_codec.sv
module rs_ilv_codec
  import rs_gf_pkg::*;
#(
  parameter int N_SYM = 10,
  parameter int K_SYM = 8,
  parameter int ILV   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enc_in_valid,
  input  logic [ILV*K_SYM*GF_M-1:0]    enc_in_data,
  output logic                         enc_out_valid,
  output logic [ILV*N_SYM*GF_M-1:0]    enc_out_data,
  input  logic                         dec_in_valid,
  input  logic [ILV*N_SYM*GF_M-1:0]    dec_in_data,
  output logic                         dec_out_valid,
  output logic [ILV*K_SYM*GF_M-1:0]    dec_out_data,
  output logic [ILV-1:0]               dec_out_uncorr
);

  localparam int NP     = N_SYM - K_SYM;
  localparam int CW_DW  = K_SYM * GF_M;
  localparam int CW_W   = N_SYM * GF_M;
  localparam int PAR_W  = NP * GF_M;
  localparam int CODE_W = ILV * CW_W;

  // encoder side
  logic [ILV-1:0][CW_DW-1:0] enc_dat;
  logic [ILV-1:0][PAR_W-1:0] enc_par;
  logic [CODE_W-1:0]         enc_code;

  // decoder side
  logic [ILV-1:0][CW_W-1:0]  rx_cw;
  logic [ILV-1:0][GF_M-1:0]  syn1, syn2;
  logic [ILV-1:0][GF_M-1:0]  s1_q, s2_q;
  logic [ILV-1:0][CW_DW-1:0] rxd_q;
  logic                      v1_q;
  logic [ILV-1:0][CW_DW-1:0] fix_dat;
  logic [ILV-1:0]            fix_bad;

  for (genvar w = 0; w < ILV; w++) begin : g_cw
    assign enc_dat[w] = enc_in_data[(ILV-w)*CW_DW-1 -: CW_DW];

    rs_cw_encoder #(.K_SYM(K_SYM)) u_enc (
      .data_i   (enc_dat[w]),
      .parity_o (enc_par[w])
    );

    rs_cw_syndrome #(.N_SYM(N_SYM)) u_syn (
      .cw_i (rx_cw[w]),
      .s1_o (syn1[w]),
      .s2_o (syn2[w])
    );

    rs_cw_corrector #(.N_SYM(N_SYM), .K_SYM(K_SYM)) u_cor (
      .s1_i     (s1_q[w]),
      .s2_i     (s2_q[w]),
      .data_i   (rxd_q[w]),
      .data_o   (fix_dat[w]),
      .uncorr_o (fix_bad[w])
    );
  end

  // symbol k of codeword w travels in line slot k*ILV + (ILV-1-w)
  always_comb begin
    enc_code = '0;
    rx_cw    = '0;
    for (int w = 0; w < ILV; w++) begin
      for (int k = 0; k < NP; k++) begin
        enc_code[(k*ILV + ILV-1-w)*GF_M +: GF_M] = enc_par[w][k*GF_M +: GF_M];
      end
      for (int k = 0; k < K_SYM; k++) begin
        enc_code[((k+NP)*ILV + ILV-1-w)*GF_M +: GF_M] = enc_dat[w][k*GF_M +: GF_M];
      end
      for (int k = 0; k < N_SYM; k++) begin
        rx_cw[w][k*GF_M +: GF_M] = dec_in_data[(k*ILV + ILV-1-w)*GF_M +: GF_M];
      end
    end
  end

  // encoder output register
  always_ff @(posedge clk) begin
    if (rst) begin
      enc_out_valid <= 1'b0;
      enc_out_data  <= '0;
    end else begin
      enc_out_valid <= enc_in_valid;
      if (enc_in_valid) enc_out_data <= enc_code;
    end
  end

  // decoder stage one: syndromes and received data nibbles
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q  <= 1'b0;
      s1_q  <= '0;
      s2_q  <= '0;
      rxd_q <= '0;
    end else begin
      v1_q <= dec_in_valid;
      if (dec_in_valid) begin
        for (int w = 0; w < ILV; w++) begin
          s1_q[w]  <= syn1[w];
          s2_q[w]  <= syn2[w];
          rxd_q[w] <= rx_cw[w][CW_W-1 -: CW_DW];
        end
      end
    end
  end

  // decoder stage two: repaired output
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_out_valid  <= 1'b0;
      dec_out_data   <= '0;
      dec_out_uncorr <= '0;
    end else begin
      dec_out_valid  <= v1_q;
      dec_out_uncorr <= '0;
      if (v1_q) begin
        for (int w = 0; w < ILV; w++) begin
          dec_out_data[(ILV-w)*CW_DW-1 -: CW_DW] <= fix_dat[w];
          dec_out_uncorr[ILV-1-w]                <= fix_bad[w];
        end
      end
    end
  end

endmodule

// File: rtl/rs_ilv_codec_chk.sv
module rs_ilv_codec_chk
  import rs_gf_pkg::*;
#(
  parameter int N_SYM = 10,
  parameter int K_SYM = 8,
  parameter int ILV   = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      enc_in_valid,
  input logic [ILV*K_SYM*GF_M-1:0] enc_in_data,
  input logic                      enc_out_valid,
  input logic [ILV*N_SYM*GF_M-1:0] enc_out_data,
  input logic                      dec_in_valid,
  input logic                      dec_out_valid,
  input logic [ILV-1:0]            dec_out_uncorr
);

  localparam int NP    = N_SYM - K_SYM;
  localparam int CW_DW = K_SYM * GF_M;

  function automatic logic [ILV*CW_DW-1:0] pick_data(logic [ILV*N_SYM*GF_M-1:0] c);
    logic [ILV*CW_DW-1:0] d;
    d = '0;
    for (int w = 0; w < ILV; w++)
      for (int k = 0; k < K_SYM; k++)
        d[(ILV-1-w)*CW_DW + k*GF_M +: GF_M] = c[((k+NP)*ILV + ILV-1-w)*GF_M +: GF_M];
    return d;
  endfunction

  function automatic logic zero_syn(logic [ILV*N_SYM*GF_M-1:0] c);
    logic ok;
    gf_t a1, a2, sym;
    ok = 1'b1;
    for (int w = 0; w < ILV; w++) begin
      a1 = '0;
      a2 = '0;
      for (int k = N_SYM - 1; k >= 0; k--) begin
        sym = c[(k*ILV + ILV-1-w)*GF_M +: GF_M];
        a1  = gf_mul(a1, gf_alpha_pow(1)) ^ sym;
        a2  = gf_mul(a2, gf_alpha_pow(2)) ^ sym;
      end
      if (a1 != '0 || a2 != '0) ok = 1'b0;
    end
    return ok;
  endfunction

  // R1
  enc_latency_chk: assert property (@(posedge clk) disable iff (rst)
    enc_in_valid |=> enc_out_valid);

  // R1
  enc_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !enc_in_valid |=> !enc_out_valid);

  // R2
  enc_systematic_chk: assert property (@(posedge clk) disable iff (rst)
    enc_in_valid |=> (pick_data(enc_out_data) == $past(enc_in_data)));

  // R3
  enc_codeword_chk: assert property (@(posedge clk) disable iff (rst)
    enc_out_valid |-> zero_syn(enc_out_data));

  // R4
  dec_latency_chk: assert property (@(posedge clk) disable iff (rst)
    dec_in_valid |=> ##1 dec_out_valid);

  // R4
  dec_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_in_valid |=> ##1 !dec_out_valid);

  // R8
  flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_out_uncorr != '0) |-> dec_out_valid);

endmodule

bind rs_ilv_codec rs_ilv_codec_chk #(.N_SYM(N_SYM), .K_SYM(K_SYM), .ILV(ILV)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .enc_in_valid   (enc_in_valid),
  .enc_in_data    (enc_in_data),
  .enc_out_valid  (enc_out_valid),
  .enc_out_data   (enc_out_data),
  .dec_in_valid   (dec_in_valid),
  .dec_out_valid  (dec_out_valid),
  .dec_out_uncorr (dec_out_uncorr)
);

// File: tb/rs_ilv_codec_bench.sv
module rs_ilv_codec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_in_valid = 1'b0;
  logic [63:0] enc_in_data  = '0;
  logic        enc_out_valid;
  logic [79:0] enc_out_data;
  logic        dec_in_valid = 1'b0;
  logic [79:0] dec_in_data  = '0;
  logic        dec_out_valid;
  logic [63:0] dec_out_data;
  logic [1:0]  dec_out_uncorr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_ilv_codec u_rs_ilv_codec (
    .clk            (clk),
    .rst            (rst),
    .enc_in_valid   (enc_in_valid),
    .enc_in_data    (enc_in_data),
    .enc_out_valid  (enc_out_valid),
    .enc_out_data   (enc_out_data),
    .dec_in_valid   (dec_in_valid),
    .dec_in_data    (dec_in_data),
    .dec_out_valid  (dec_out_valid),
    .dec_out_data   (dec_out_data),
    .dec_out_uncorr (dec_out_uncorr)
  );

  // bench-side GF(16), x^4 + x + 1
  function automatic logic [3:0] bmul(logic [3:0] a, logic [3:0] b);
    logic [3:0] p, s;
    p = 4'd0;
    s = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ s;
      s = s[3] ? ({s[2:0], 1'b0} ^ 4'b0011) : {s[2:0], 1'b0};
    end
    return p;
  endfunction

  // codeword w (0 = A, 1 = B) syndrome at root r
  function automatic logic [3:0] bsyn(logic [79:0] blk, int w, logic [3:0] r);
    logic [3:0] acc;
    acc = 4'd0;
    for (int k = 9; k >= 0; k--) acc = bmul(acc, r) ^ blk[8*k + 4*(1-w) +: 4];
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_enc(input logic [63:0] d, output logic [79:0] c);
    @(negedge clk);
    enc_in_valid = 1'b1;
    enc_in_data  = d;
    @(negedge clk);
    enc_in_valid = 1'b0;
    chk(enc_out_valid == 1'b1, "R1 enc valid after one clock", 80'(enc_out_valid), 80'd1);
    c = enc_out_data;
    @(negedge clk);
    chk(enc_out_valid == 1'b0, "R1 enc valid drops", 80'(enc_out_valid), 80'd0);
  endtask

  task automatic run_dec(input logic [79:0] b, output logic [63:0] d, output logic [1:0] f);
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_data  = b;
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk(dec_out_valid == 1'b0, "R4 dec not early", 80'(dec_out_valid), 80'd0);
    @(negedge clk);
    chk(dec_out_valid == 1'b1, "R4 dec valid after two clocks", 80'(dec_out_valid), 80'd1);
    d = dec_out_data;
    f = dec_out_uncorr;
    @(negedge clk);
    chk(dec_out_valid == 1'b0 && dec_out_uncorr == 2'b00, "R8 flags low without valid",
        {77'd0, dec_out_valid, dec_out_uncorr}, 80'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(enc_out_valid == 1'b0 && dec_out_valid == 1'b0 && dec_out_uncorr == 2'b00,
        "R10 outputs idle in reset", {77'd0, enc_out_valid, dec_out_valid, dec_out_uncorr[0]}, 80'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_encode(input logic [63:0] d);
    logic [79:0] c;
    logic [63:0] sys;
    run_enc(d, c);
    for (int k = 0; k < 8; k++) begin
      sys[32 + 4*k +: 4] = c[8*(k+2) + 4 +: 4];
      sys[4*k +: 4]      = c[8*(k+2) +: 4];
    end
    chk(sys == d, "R2 systematic interleave", 80'(sys), 80'(d));
    for (int w = 0; w < 2; w++) begin
      chk(bsyn(c, w, 4'd2) == 4'd0 && bsyn(c, w, 4'd4) == 4'd0, "R3 codeword roots",
          {72'd0, bsyn(c, w, 4'd2), bsyn(c, w, 4'd4)}, 80'd0);
    end
  endtask

  task automatic t_known();
    logic [79:0] c;
    run_enc(64'd0, c);
    chk(c == 80'd0, "R3 zero word", c, 80'd0);
    run_enc(64'h0000_0001_0000_0000, c);
    chk(c == 80'h0000_0000_0000_0010_6080, "R3 unit symbol parity", c, 80'h0000_0000_0000_0010_6080);
  endtask

  task automatic t_roundtrip(input logic [63:0] d, input logic [79:0] emask,
                             input logic [63:0] dexp, input logic [1:0] fexp, input string req);
    logic [79:0] c;
    logic [63:0] q;
    logic [1:0]  f;
    run_enc(d, c);
    run_dec(c ^ emask, q, f);
    chk(q == dexp, req, 80'(q), 80'(dexp));
    chk(f == fexp, req, 80'(f), 80'(fexp));
  endtask

  task automatic t_single();
    logic [63:0] d;
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 10; k++) begin
        d = {$urandom(), $urandom()};
        t_roundtrip(d, 80'(((k + 3*w) % 15) + 1) << (8*k + 4*(1-w)), d, 2'b00,
                    "R6 single symbol repair");
      end
    end
  endtask

  task automatic t_both();
    logic [63:0] d;
    for (int k = 0; k < 10; k++) begin
      d = {$urandom(), $urandom()};
      t_roundtrip(d, (80'(k + 1) << (8*k + 4)) | (80'(15 - k) << (8*((k + 3) % 10))), d, 2'b00,
                  "R7 one error per codeword");
    end
  endtask

  task automatic t_burst();
    logic [63:0] d;
    for (int off = 0; off <= 75; off += 5) begin
      d = {$urandom(), $urandom()};
      t_roundtrip(d, 80'h1F << off, d, 2'b00, "R7 five bit burst");
    end
    d = {$urandom(), $urandom()};
    t_roundtrip(d, 80'h1F << 2, d, 2'b00, "R7 five bit burst straddle");
  endtask

  task automatic t_uncorr();
    logic [63:0] d;
    // A: S1 zero, errors on data symbols 2 and 3
    d = 64'h0123_4567_89AB_CDEF;
    t_roundtrip(d, (80'd2 << 20) | (80'd1 << 28), d ^ 64'h0000_0012_0000_0000, 2'b10,
                "R8 syndrome one zero");
    // A: S2 zero
    d = 64'hFEDC_BA98_7654_3210;
    t_roundtrip(d, (80'd4 << 20) | (80'd1 << 28), d ^ 64'h0000_0014_0000_0000, 2'b10,
                "R8 syndrome two zero");
    // B: location outside the ten positions
    d = 64'hA5A5_5A5A_0F0F_F0F0;
    t_roundtrip(d, (80'd1 << 72) | (80'd1 << 64), d ^ 64'h0000_0000_1100_0000, 2'b01,
                "R8 location beyond range");
    // A flagged while B holds one repairable error
    d = 64'h1357_9BDF_2468_ACE0;
    t_roundtrip(d, (80'd2 << 20) | (80'd1 << 28) | (80'd9 << 40), d ^ 64'h0000_0012_0000_0000, 2'b10,
                "R9 neighbour still repaired");
  endtask

  initial begin : wd
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] q;
    logic [79:0] c;
    t_reset();
    t_known();
    t_encode(64'hFFFF_FFFF_FFFF_FFFF);
    t_encode(64'h0123_4567_89AB_CDEF);
    for (int i = 0; i < 6; i++) t_encode({$urandom(), $urandom()});
    q = 64'hDEAD_BEEF_CAFE_F00D;
    t_roundtrip(q, 80'd0, q, 2'b00, "R5 clean block");
    t_roundtrip(64'd0, 80'd0, 64'd0, 2'b00, "R5 clean zero block");
    t_single();
    t_both();
    t_burst();
    t_uncorr();
    run_enc(64'h5555_AAAA_3333_CCCC, c);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule